// File: doc/BRIEF.md
# Dimension-Split Mesh Router Node

This block is one switching node of a two-dimensional on-chip mesh. It has five channels, each with an input side and an output side that use a valid/ready handshake. Four channels face the neighbouring nodes (east, west, north, south). The fifth faces the attached core. Every packet carries a destination column and row. The node's own column and row, and the size of the mesh, are fixed by parameters. Packets travel along the row first. Once the column matches, they travel along the column. When both coordinates match, the packet goes to the core.

Switching is not one monolithic five-by-five crossbar. A row sub-switch drives only the east and west outputs, and a column sub-switch drives only the north and south outputs. Each of them offers one candidate for delivery to the core, and a final two-way arbiter picks between the two candidates. An input can reach at most two sub-switches. A packet that keeps its direction enters its output through a dedicated straight path, which bypasses the turn multiplexer. Each input holds one packet. Each output arbitrates round-robin among the inputs that can reach it. Each sub-switch has an enable output that is low whenever no held packet needs that sub-switch, which models power gating.

Top module: `mnr_mesh_router`

## Requirements
- R1: Channel index encoding on all five-bit vectors is bit 0 core, bit 1 east, bit 2 west, bit 3 north, bit 4 south. A flit is {dest column, dest row, payload}, with the column in the top bits. East means a larger column and north means a larger row. A packet whose column differs leaves east or west. Otherwise, a packet whose row differs leaves north or south. Otherwise it goes to the core output.
- R2: A packet entered on the core input and addressed to this node is accepted and discarded. It never appears on the core output or on any other output.
- R3: A hop that would use a missing neighbour link, or leave through the channel the packet came in on, is treated as a matched coordinate. A packet that arrives from north or south ignores its column. Outputs toward missing neighbours never raise valid.
- R4: When several inputs wait on one output, they are served round-robin. The priority rotates past the last input served. The core output alternates between the row and column sub-switches, and within each sub-switch between its two inputs.
- R5: Each input holds one packet. While that packet is held and not leaving, the input's ready is low. Ready rises in the same cycle that the packet's output handshake completes.
- R6: While an output has valid high and ready low, valid stays high and the flit stays unchanged until the transfer.
- R7: The row enable is high only while a held packet targets east or west, or targets the core after arriving from east or west. The column enable follows the same rule for north, south and packets arriving from north or south. Outputs of a disabled sub-switch stay idle.
- R8: An uncontested packet accepted at a clock edge is valid on its output right after that edge. It leaves at the first edge where that output's ready is high, and it is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 5 | Per-channel input valid |
| in_ready | output | 5 | Per-channel input ready |
| in_flit | input | 5*(X_W+Y_W+PAYLOAD_W) | Input flits, channel i in slice i |
| out_valid | output | 5 | Per-channel output valid |
| out_ready | input | 5 | Per-channel output ready from downstream |
| out_flit | output | 5*(X_W+Y_W+PAYLOAD_W) | Output flits, channel i in slice i |
| row_sw_en | output | 1 | Row sub-switch enable |
| col_sw_en | output | 1 | Column sub-switch enable |

## Verification
The assertions check several properties on every cycle. Outputs hold steady under back-pressure. Grants are one-hot and always go to a requester. A held packet stays put until it is dequeued. No input ever requests an output it has no wire to. Missing links stay silent. Outputs stay idle while their sub-switch is disabled. The directed scenarios show the properties that depend on a sequence of events. These are the actual route chosen for each destination, the order of service under contention at a turn output and at the core output, the discarding of self-addressed core packets, and the clamping of out-of-mesh coordinates at a corner node.

// File: rtl/mnr_pkg.sv
package mnr_pkg;
  localparam int NCH = 5;
  localparam int CH_L = 0;
  localparam int CH_E = 1;
  localparam int CH_W = 2;
  localparam int CH_N = 3;
  localparam int CH_S = 4;

  // Outputs an input has a physical path to, bit order {S,N,W,E,L}.
  function automatic logic [4:0] reach_mask(int ch);
    case (ch)
      CH_L:    reach_mask = 5'b11110;
      CH_E:    reach_mask = 5'b11101;
      CH_W:    reach_mask = 5'b11011;
      CH_N:    reach_mask = 5'b10001;
      default: reach_mask = 5'b01001;
    endcase
  endfunction
endpackage

// File: rtl/mnr_rr_arb.sv
module mnr_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_d, gidx;
  logic          hold_q, hold_d;
  logic [N-1:0]  held_q, held_d, pick;

  always_comb begin : p_pick
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(ptr_q) + k) % N;
      if (!found && req[c]) begin
        found   = 1'b1;
        pick[c] = 1'b1;
      end
    end
  end

  assign gnt = hold_q ? held_q : pick;

  always_comb begin
    gidx = '0;
    for (int k = 0; k < N; k++) begin
      if (gnt[k]) gidx = IW'(k);
    end
  end

  always_comb begin
    ptr_d  = ptr_q;
    hold_d = hold_q;
    held_d = held_q;
    if (adv) begin
      ptr_d  = gidx;
      hold_d = 1'b0;
    end else if (|req) begin
      hold_d = 1'b1;
      held_d = gnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= IW'(N - 1);
      hold_q <= 1'b0;
      held_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      hold_q <= hold_d;
      held_q <= held_d;
    end
  end

  p_gnt_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_gnt_to_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> (|(gnt & req)));
  p_req_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

// File: rtl/mnr_in_buf.sv
module mnr_in_buf
  import mnr_pkg::*;
#(
  parameter int CH        = 0,
  parameter int X_W       = 3,
  parameter int Y_W       = 3,
  parameter int PAYLOAD_W = 8,
  parameter int NODE_X    = 1,
  parameter int NODE_Y    = 1,
  parameter int MESH_COLS = 4,
  parameter int MESH_ROWS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [X_W+Y_W+PAYLOAD_W-1:0]   in_flit,
  input  logic                           deq,
  output logic                           full,
  output logic [X_W+Y_W+PAYLOAD_W-1:0]   flit_q,
  output logic [4:0]                     dir_q,
  output logic                           uses_row,
  output logic                           uses_col
);
  localparam int FLIT_W = X_W + Y_W + PAYLOAD_W;
  localparam logic [X_W-1:0] NX = X_W'(NODE_X);
  localparam logic [Y_W-1:0] NY = Y_W'(NODE_Y);
  localparam bit HAS_E = (NODE_X < MESH_COLS - 1) && (CH != CH_E);
  localparam bit HAS_W = (NODE_X > 0) && (CH != CH_W);
  localparam bit HAS_N = (NODE_Y < MESH_ROWS - 1) && (CH != CH_N);
  localparam bit HAS_S = (NODE_Y > 0) && (CH != CH_S);
  localparam bit COL_IN = (CH == CH_N) || (CH == CH_S);
  localparam bit ROW_IN = (CH == CH_E) || (CH == CH_W);

  logic [X_W-1:0] dx;
  logic [Y_W-1:0] dy;
  logic [4:0]     dir_d;
  logic           full_q, full_d, load, self_drop;
  logic [FLIT_W-1:0] flit_d;
  logic [4:0]     dir_n;

  assign dx = in_flit[FLIT_W-1 -: X_W];
  assign dy = in_flit[PAYLOAD_W+Y_W-1 -: Y_W];

  // Dimension-ordered next hop with clamping at edges and no reversal.
  always_comb begin
    dir_d = '0;
    if (!COL_IN && HAS_E && (dx > NX))      dir_d[CH_E] = 1'b1;
    else if (!COL_IN && HAS_W && (dx < NX)) dir_d[CH_W] = 1'b1;
    else if (HAS_N && (dy > NY))            dir_d[CH_N] = 1'b1;
    else if (HAS_S && (dy < NY))            dir_d[CH_S] = 1'b1;
    else                                    dir_d[CH_L] = 1'b1;
  end

  assign self_drop = (CH == CH_L) && dir_d[CH_L];
  assign in_ready  = !full_q || deq;
  assign load      = in_valid && in_ready && !self_drop;

  always_comb begin
    full_d = full_q;
    flit_d = flit_q;
    dir_n  = dir_q;
    if (load) begin
      full_d = 1'b1;
      flit_d = in_flit;
      dir_n  = dir_d;
    end else if (deq) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      flit_q <= '0;
      dir_q  <= '0;
    end else begin
      full_q <= full_d;
      flit_q <= flit_d;
      dir_q  <= dir_n;
    end
  end

  assign full     = full_q;
  assign uses_row = full_q && (dir_q[CH_E] || dir_q[CH_W] || (dir_q[CH_L] && ROW_IN));
  assign uses_col = full_q && (dir_q[CH_N] || dir_q[CH_S] || (dir_q[CH_L] && COL_IN));

  p_hold_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !deq) |=> (full_q && $stable(flit_q) && $stable(dir_q)));
  p_deq_needs_pkt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> full_q);
  p_one_hop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> $onehot(dir_q));

  if (CH == CH_L) begin : g_core_in
    p_no_self_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> !dir_q[CH_L]);
  end
endmodule

// File: rtl/mnr_out_port.sv
module mnr_out_port #(
  parameter int NT     = 1,
  parameter int FLIT_W = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 str_req,
  input  logic [FLIT_W-1:0]    str_flit,
  input  logic [NT-1:0]        turn_req,
  input  logic [NT*FLIT_W-1:0] turn_flit,
  input  logic                 ready,
  output logic                 valid,
  output logic [FLIT_W-1:0]    flit,
  output logic                 str_xfer,
  output logic [NT-1:0]        turn_xfer
);
  localparam int NR = NT + 1;

  logic [NR-1:0] req, gnt;
  logic          adv;

  assign req   = {turn_req, str_req};
  assign valid = en && (|req);
  assign adv   = valid && ready;

  mnr_rr_arb #(.N(NR)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .adv  (adv),
    .gnt  (gnt)
  );

  // Straight traffic takes the direct leg; turning traffic goes through the mux.
  always_comb begin
    flit = str_flit;
    for (int k = 0; k < NT; k++) begin
      if (gnt[k+1]) flit = turn_flit[k*FLIT_W +: FLIT_W];
    end
  end

  assign str_xfer  = adv && gnt[0];
  assign turn_xfer = {NT{adv}} & gnt[NR-1:1];

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(flit)));
endmodule

// File: rtl/mnr_subswitch.sv
module mnr_subswitch #(
  parameter int NT     = 1,
  parameter int FLIT_W = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [1:0]             str_req,
  input  logic [2*FLIT_W-1:0]    str_flit,
  input  logic [2*NT-1:0]        turn_req,
  input  logic [NT*FLIT_W-1:0]   turn_flit,
  input  logic [1:0]             out_ready,
  output logic [1:0]             out_valid,
  output logic [2*FLIT_W-1:0]    out_flit,
  output logic [1:0]             str_xfer,
  output logic [NT-1:0]          turn_xfer,
  input  logic [1:0]             loc_req,
  input  logic [2*FLIT_W-1:0]    loc_flit,
  input  logic                   loc_take,
  output logic                   loc_valid,
  output logic [FLIT_W-1:0]      loc_out_flit,
  output logic [1:0]             loc_xfer
);
  logic [2*NT-1:0] tx;
  logic [1:0]      lg;

  for (genvar g = 0; g < 2; g++) begin : g_out
    mnr_out_port #(.NT(NT), .FLIT_W(FLIT_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .str_req  (str_req[g]),
      .str_flit (str_flit[g*FLIT_W +: FLIT_W]),
      .turn_req (turn_req[g*NT +: NT]),
      .turn_flit(turn_flit),
      .ready    (out_ready[g]),
      .valid    (out_valid[g]),
      .flit     (out_flit[g*FLIT_W +: FLIT_W]),
      .str_xfer (str_xfer[g]),
      .turn_xfer(tx[g*NT +: NT])
    );
  end

  assign turn_xfer = tx[NT-1:0] | tx[2*NT-1:NT];

  mnr_rr_arb #(.N(2)) u_loc_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (loc_req),
    .adv  (loc_take),
    .gnt  (lg)
  );

  assign loc_valid    = en && (|loc_req);
  assign loc_out_flit = lg[1] ? loc_flit[FLIT_W +: FLIT_W] : loc_flit[0 +: FLIT_W];
  assign loc_xfer     = lg & {2{loc_take}};

  p_loc_cand_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && !loc_take) |=> (loc_valid && $stable(loc_out_flit)));
endmodule

// File: rtl/mnr_mesh_router.sv
module mnr_mesh_router
  import mnr_pkg::*;
#(
  parameter int X_W       = 3,
  parameter int Y_W       = 3,
  parameter int PAYLOAD_W = 8,
  parameter int MESH_COLS = 4,
  parameter int MESH_ROWS = 4,
  parameter int NODE_X    = 1,
  parameter int NODE_Y    = 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [4:0]                           in_valid,
  output logic [4:0]                           in_ready,
  input  logic [5*(X_W+Y_W+PAYLOAD_W)-1:0]     in_flit,
  output logic [4:0]                           out_valid,
  input  logic [4:0]                           out_ready,
  output logic [5*(X_W+Y_W+PAYLOAD_W)-1:0]     out_flit,
  output logic                                 row_sw_en,
  output logic                                 col_sw_en
);
  localparam int FLIT_W = X_W + Y_W + PAYLOAD_W;
  localparam bit HAS_E = (NODE_X < MESH_COLS - 1);
  localparam bit HAS_W = (NODE_X > 0);
  localparam bit HAS_N = (NODE_Y < MESH_ROWS - 1);
  localparam bit HAS_S = (NODE_Y > 0);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [4:0]        full, deq, urow, ucol;
  logic [FLIT_W-1:0] fq    [NCH];
  logic [4:0]        dir_q [NCH];
  logic [4:0]        rq    [NCH];

  for (genvar p = 0; p < NCH; p++) begin : g_in
    mnr_in_buf #(
      .CH(p), .X_W(X_W), .Y_W(Y_W), .PAYLOAD_W(PAYLOAD_W),
      .NODE_X(NODE_X), .NODE_Y(NODE_Y),
      .MESH_COLS(MESH_COLS), .MESH_ROWS(MESH_ROWS)
    ) u_buf (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .in_valid(in_valid[p]),
      .in_ready(in_ready[p]),
      .in_flit (in_flit[p*FLIT_W +: FLIT_W]),
      .deq     (deq[p]),
      .full    (full[p]),
      .flit_q  (fq[p]),
      .dir_q   (dir_q[p]),
      .uses_row(urow[p]),
      .uses_col(ucol[p])
    );
    assign rq[p] = dir_q[p] & {5{full[p]}};
  end

  assign row_sw_en = |urow;
  assign col_sw_en = |ucol;

  // Row sub-switch: slot 0 drives east, slot 1 drives west.
  logic [1:0]          row_ov, row_sx, row_lx;
  logic [2*FLIT_W-1:0] row_of;
  logic [0:0]          row_tx;
  logic                row_lv, row_take;
  logic [FLIT_W-1:0]   row_lf;

  mnr_subswitch #(.NT(1), .FLIT_W(FLIT_W)) u_row (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .en          (row_sw_en),
    .str_req     ({rq[CH_E][CH_W], rq[CH_W][CH_E]}),
    .str_flit    ({fq[CH_E], fq[CH_W]}),
    .turn_req    ({rq[CH_L][CH_W], rq[CH_L][CH_E]}),
    .turn_flit   (fq[CH_L]),
    .out_ready   ({out_ready[CH_W], out_ready[CH_E]}),
    .out_valid   (row_ov),
    .out_flit    (row_of),
    .str_xfer    (row_sx),
    .turn_xfer   (row_tx),
    .loc_req     ({rq[CH_W][CH_L], rq[CH_E][CH_L]}),
    .loc_flit    ({fq[CH_W], fq[CH_E]}),
    .loc_take    (row_take),
    .loc_valid   (row_lv),
    .loc_out_flit(row_lf),
    .loc_xfer    (row_lx)
  );

  // Column sub-switch: slot 0 drives north, slot 1 drives south.
  // Turning sources in order east, west, core.
  logic [1:0]          col_ov, col_sx, col_lx;
  logic [2*FLIT_W-1:0] col_of;
  logic [2:0]          col_tx;
  logic                col_lv, col_take;
  logic [FLIT_W-1:0]   col_lf;

  mnr_subswitch #(.NT(3), .FLIT_W(FLIT_W)) u_col (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .en          (col_sw_en),
    .str_req     ({rq[CH_N][CH_S], rq[CH_S][CH_N]}),
    .str_flit    ({fq[CH_N], fq[CH_S]}),
    .turn_req    ({rq[CH_L][CH_S], rq[CH_W][CH_S], rq[CH_E][CH_S],
                   rq[CH_L][CH_N], rq[CH_W][CH_N], rq[CH_E][CH_N]}),
    .turn_flit   ({fq[CH_L], fq[CH_W], fq[CH_E]}),
    .out_ready   ({out_ready[CH_S], out_ready[CH_N]}),
    .out_valid   (col_ov),
    .out_flit    (col_of),
    .str_xfer    (col_sx),
    .turn_xfer   (col_tx),
    .loc_req     ({rq[CH_S][CH_L], rq[CH_N][CH_L]}),
    .loc_flit    ({fq[CH_S], fq[CH_N]}),
    .loc_take    (col_take),
    .loc_valid   (col_lv),
    .loc_out_flit(col_lf),
    .loc_xfer    (col_lx)
  );

  // Core output: rotate between the two sub-switch candidates.
  logic [1:0] fin_req, fin_gnt;
  logic       fin_adv;

  assign fin_req = {col_lv, row_lv};
  assign fin_adv = out_valid[CH_L] && out_ready[CH_L];

  mnr_rr_arb #(.N(2)) u_core_arb (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .req  (fin_req),
    .adv  (fin_adv),
    .gnt  (fin_gnt)
  );

  assign row_take = fin_adv && fin_gnt[0];
  assign col_take = fin_adv && fin_gnt[1];

  assign out_valid[CH_L] = |fin_req;
  assign out_valid[CH_E] = row_ov[0];
  assign out_valid[CH_W] = row_ov[1];
  assign out_valid[CH_N] = col_ov[0];
  assign out_valid[CH_S] = col_ov[1];

  assign out_flit[CH_L*FLIT_W +: FLIT_W] = fin_gnt[1] ? col_lf : row_lf;
  assign out_flit[CH_E*FLIT_W +: FLIT_W] = row_of[0 +: FLIT_W];
  assign out_flit[CH_W*FLIT_W +: FLIT_W] = row_of[FLIT_W +: FLIT_W];
  assign out_flit[CH_N*FLIT_W +: FLIT_W] = col_of[0 +: FLIT_W];
  assign out_flit[CH_S*FLIT_W +: FLIT_W] = col_of[FLIT_W +: FLIT_W];

  assign deq[CH_L] = row_tx[0] | col_tx[2];
  assign deq[CH_E] = row_sx[1] | row_lx[0] | col_tx[0];
  assign deq[CH_W] = row_sx[0] | row_lx[1] | col_tx[1];
  assign deq[CH_N] = col_sx[1] | col_lx[0];
  assign deq[CH_S] = col_sx[0] | col_lx[1];

  // Checks across buffers, sub-switches and the core arbiter.
  for (genvar p = 0; p < NCH; p++) begin : g_chk
    p_path_exists_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
      (rq[p] & ~reach_mask(p)) == 5'b0);
  end

  p_core_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (out_valid[CH_L] && !out_ready[CH_L]) |=>
      (out_valid[CH_L] && $stable(out_flit[CH_L*FLIT_W +: FLIT_W])));
  p_row_gate_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !row_sw_en |-> !(out_valid[CH_E] || out_valid[CH_W]));
  p_col_gate_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !col_sw_en |-> !(out_valid[CH_N] || out_valid[CH_S]));
  p_edge_links_r3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !((!HAS_E && out_valid[CH_E]) || (!HAS_W && out_valid[CH_W]) ||
      (!HAS_N && out_valid[CH_N]) || (!HAS_S && out_valid[CH_S])));
endmodule

// File: tb/mnr_mesh_router_bench.sv
module mnr_mesh_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 14;
  localparam int L = 0, E = 1, W = 2, N = 3, S = 4;

  logic clk, rst_n;
  logic [4:0] in_valid, in_ready, out_valid, out_ready;
  logic [5*FW-1:0] in_flit, out_flit;
  logic row_en, col_en;

  logic [4:0] c_in_valid, c_in_ready, c_out_valid, c_out_ready;
  logic [5*FW-1:0] c_in_flit, c_out_flit;
  logic c_row_en, c_col_en;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  mnr_mesh_router u_mnr_mesh_router (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .row_sw_en(row_en), .col_sw_en(col_en)
  );

  mnr_mesh_router #(.NODE_X(3), .NODE_Y(3)) u_mnr_mesh_router_corner (
    .clk(clk), .rst_n(rst_n),
    .in_valid(c_in_valid), .in_ready(c_in_ready), .in_flit(c_in_flit),
    .out_valid(c_out_valid), .out_ready(c_out_ready), .out_flit(c_out_flit),
    .row_sw_en(c_row_en), .col_sw_en(c_col_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [FW-1:0] mk(int x, int y, int pl);
    mk = {3'(x), 3'(y), 8'(pl)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(int p, logic [FW-1:0] f);
    in_flit[p*FW +: FW] = f;
    in_valid[p] = 1'b1;
    while (!in_ready[p]) @(negedge clk);
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic c_send(int p, logic [FW-1:0] f);
    c_in_flit[p*FW +: FW] = f;
    c_in_valid[p] = 1'b1;
    while (!c_in_ready[p]) @(negedge clk);
    @(negedge clk);
    c_in_valid[p] = 1'b0;
  endtask

  task automatic route_one(string tag, int src, logic [FW-1:0] f, int dst);
    send(src, f);
    check({tag, " valid"}, 32'(out_valid), 32'(5'b1 << dst));
    check({tag, " flit"}, 32'(out_flit[dst*FW +: FW]), 32'(f));
    @(negedge clk);
    check({tag, " once"}, 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset;
    check("R5 reset ready", 32'(in_ready), 32'h1f);
    check("R8 reset valid", 32'(out_valid), 32'd0);
    check("R7 reset enables", {30'd0, row_en, col_en}, 32'd0);
  endtask

  task automatic t_routes;
    out_ready = 5'h1f;
    route_one("R1 core->E", L, mk(3, 0, 8'h11), E);
    route_one("R1 core->W", L, mk(0, 3, 8'h12), W);
    route_one("R1 core->N", L, mk(1, 3, 8'h13), N);
    route_one("R1 core->S", L, mk(1, 0, 8'h14), S);
    route_one("R8 W->E straight", W, mk(3, 2, 8'h15), E);
    route_one("R1 E->W straight", E, mk(0, 3, 8'h16), W);
    route_one("R1 E->S turn", E, mk(1, 0, 8'h17), S);
    route_one("R3 N in ignores column", N, mk(3, 0, 8'h18), S);
    send(W, mk(1, 1, 8'h19));
    check("R1 W->core valid", 32'(out_valid), 32'(5'b1 << L));
    check("R1 W->core flit", 32'(out_flit[L*FW +: FW]), 32'(mk(1, 1, 8'h19)));
    check("R7 row enable for row-core", {30'd0, row_en, col_en}, 32'd2);
    @(negedge clk);
  endtask

  task automatic t_self_drop;
    send(L, mk(1, 1, 8'h2a));
    check("R2 no output", 32'(out_valid), 32'd0);
    check("R2 core input free", 32'(in_ready[L]), 32'd1);
    check("R2 enables idle", {30'd0, row_en, col_en}, 32'd0);
    @(negedge clk);
    check("R2 still no output", 32'(out_valid), 32'd0);
  endtask

  task automatic t_backpressure;
    logic [FW-1:0] f;
    f = mk(3, 1, 8'h44);
    out_ready = 5'h1f & ~(5'b1 << E);
    send(W, f);
    check("R5 valid E", 32'(out_valid), 32'(5'b1 << E));
    check("R5 blocked not ready", 32'(in_ready[W]), 32'd0);
    check("R7 row only", {30'd0, row_en, col_en}, 32'd2);
    @(negedge clk);
    check("R6 valid held", 32'(out_valid[E]), 32'd1);
    check("R6 flit held", 32'(out_flit[E*FW +: FW]), 32'(f));
    out_ready[E] = 1'b1;
    #1;
    check("R5 ready on transfer", 32'(in_ready[W]), 32'd1);
    @(negedge clk);
    check("R8 single delivery", 32'(out_valid), 32'd0);
    out_ready[S] = 1'b0;
    send(N, mk(2, 0, 8'h55));
    check("R7 column only", {30'd0, row_en, col_en}, 32'd1);
    check("R6 S held", 32'(out_valid[S]), 32'd1);
    out_ready[S] = 1'b1;
    @(negedge clk);
    check("R7 idle after drain", {30'd0, row_en, col_en}, 32'd0);
  endtask

  task automatic t_rr_north;
    logic [7:0] exp_pl [4];
    exp_pl[0] = 8'h61; exp_pl[1] = 8'h62; exp_pl[2] = 8'h63; exp_pl[3] = 8'h64;
    out_ready[N] = 1'b0;
    in_flit[S*FW +: FW] = mk(1, 3, 8'h61);
    in_flit[E*FW +: FW] = mk(1, 3, 8'h62);
    in_flit[W*FW +: FW] = mk(1, 2, 8'h63);
    in_flit[L*FW +: FW] = mk(1, 3, 8'h64);
    in_valid = 5'b1 << S | 5'b1 << E | 5'b1 << W | 5'b1 << L;
    @(negedge clk);
    in_valid = '0;
    check("R6 N held first", 32'(out_flit[N*FW +: 8]), 32'h61);
    out_ready[N] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check("R4 north rotation", 32'(out_flit[N*FW +: 8]), 32'(exp_pl[i]));
      @(negedge clk);
    end
    check("R4 north drained", 32'(out_valid[N]), 32'd0);
  endtask

  task automatic t_rr_core;
    logic [7:0] exp_pl [4];
    exp_pl[0] = 8'h73; exp_pl[1] = 8'h71; exp_pl[2] = 8'h74; exp_pl[3] = 8'h72;
    out_ready[L] = 1'b0;
    in_flit[E*FW +: FW] = mk(1, 1, 8'h71);
    in_flit[W*FW +: FW] = mk(1, 1, 8'h72);
    in_flit[N*FW +: FW] = mk(1, 1, 8'h73);
    in_flit[S*FW +: FW] = mk(1, 1, 8'h74);
    in_valid = 5'b1 << E | 5'b1 << W | 5'b1 << N | 5'b1 << S;
    @(negedge clk);
    in_valid = '0;
    check("R7 both enabled", {30'd0, row_en, col_en}, 32'd3);
    out_ready[L] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check("R4 core rotation", 32'(out_flit[L*FW +: 8]), 32'(exp_pl[i]));
      @(negedge clk);
    end
    check("R4 core drained", 32'(out_valid[L]), 32'd0);
  endtask

  task automatic t_corner;
    c_out_ready = 5'h1f;
    c_send(W, mk(7, 5, 8'h81));
    check("R3 corner clamp to core", 32'(c_out_valid), 32'(5'b1 << L));
    check("R3 corner core flit", 32'(c_out_flit[L*FW +: FW]), 32'(mk(7, 5, 8'h81)));
    @(negedge clk);
    c_send(S, mk(3, 6, 8'h82));
    check("R3 corner row clamp", 32'(c_out_valid), 32'(5'b1 << L));
    @(negedge clk);
    c_send(L, mk(5, 1, 8'h83));
    check("R3 corner column clamp to S", 32'(c_out_valid), 32'(5'b1 << S));
    check("R3 corner missing links idle", 32'(c_out_valid & 5'b01010), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = '0; in_flit = '0; out_ready = '0;
    c_in_valid = '0; c_in_flit = '0; c_out_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_routes();
    t_self_drop();
    t_backpressure();
    t_rr_north();
    t_rr_core();
    t_corner();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule